// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Bit-Clock Master

The block sends stereo audio samples out over a three-wire serial link: bit clock, frame clock and data. It can run as clock master or as clock slave. As master it divides its system clock, which is the master clock at 256, 384, 512 or 768 times the frame rate, into a bit clock of 64 times the frame rate and a frame clock. As slave it takes both clocks from outside, passes them through synchronisers and follows their edges.

Each half frame starts with a load of a 32-bit shift register. The sample is placed in the slot according to one of four layouts: right-justified 16 bit, right-justified 20 bit, left-justified 20 bit, or the I2S layout with the MSB one bit after the frame-clock edge. Data is shifted out MSB first on each falling bit-clock edge. The clock-mode and format selects are taken only while reset is held. The data line stays low through reset and until a stereo pair marked valid has been captured at the start of a left half. In slave mode, a frame clock that stops forces the line low again.

Top module: `aud_ser_tx`

## Requirements
- R1: `clk_mode_i` and `fmt_i` are latched on every clock edge while `rst_n` is low. Changes to them while `rst_n` is high have no effect.
- R2: Latched codes 0, 1, 2, 3 and 7 select master mode, with bit-clock periods of 4, 6, 8, 12 and 4 `clk` cycles and a high phase of half the period. After reset is released, `bclk_o` rises on clock edge N/2 and first falls on edge N, where N is the period.
- R3: In master mode `lrclk_o` changes only when `bclk_o` falls. A frame is 64 bit clocks and each half is 32. During the left half `lrclk_o` is 1 for formats 0 to 2 and 0 for format 3. The first fall after reset starts a left half, and before it `lrclk_o` shows the right-half level.
- R4: Code 4 (slave) and the reserved codes 5 and 6 hold `bclk_o` and `lrclk_o` low. Codes 5 and 6 also hold `sdata_o` low.
- R5: `sdata_o` changes only on a bit-clock falling edge, or when the slave timeout silences it. Bits are sent MSB first in two's complement.
- R6: Format 0 (right-justified 16): slot positions 0 to 15 are 0, and positions 16 to 31 carry sample bits 19 down to 4.
- R7: Format 1 (right-justified 20): slot positions 0 to 11 are 0, and positions 12 to 31 carry sample bits 19 down to 0.
- R8: Format 2 (left-justified): slot positions 0 to 19 carry sample bits 19 down to 0, and positions 20 to 31 are 0.
- R9: Format 3 (I2S layout): position 0 is 0, positions 1 to 20 carry sample bits 19 down to 0, and the rest are 0.
- R10: `sdata_o` is low during reset and until a left half starts while `smp_valid_i` is high. `left_i` and `right_i` are both captured at the start of each left half, and the captured right value is sent in the following right half.
- R11: In slave mode a half frame starts at a falling edge of `bclk_i` at which `lrclk_i` shows the other half's level. The level meanings are the same as in R3. Data follows the falling edge of `bclk_i` after three `clk` edges.
- R12: In slave mode, if `lrclk_i` shows no edge for `TMO` `clk` cycles, `sdata_o` goes low. It stays low until the frame clock toggles again and a valid left half starts.
- R13: `bypass_o` is high exactly when the latched clock mode is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; master clock in master mode |
| rst_n | input | 1 | Synchronous active-low reset; selects latched while low |
| clk_mode_i | input | 3 | Clock-mode select |
| fmt_i | input | 2 | Output slot format select |
| left_i | input | SW | Left sample, two's complement |
| right_i | input | SW | Right sample, two's complement |
| smp_valid_i | input | 1 | Sample pair on the inputs is valid |
| bclk_i | input | 1 | External bit clock (slave) |
| lrclk_i | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Generated bit clock (master), else low |
| lrclk_o | output | 1 | Generated frame clock (master), else low |
| sdata_o | output | 1 | Serial data |
| bypass_o | output | 1 | Latched mode is master-with-bypass |

## Verification
In master mode, a behavioural model keyed on the clock count is compared with every output on every cycle for each divider and each format. A divider that is off by one, a wrongly placed bit-clock edge, or a layout with the MSB in the wrong slot position shows up as a mismatch on the first bit it affects. A run that holds `smp_valid_i` low for the first frame catches a design that sends samples too early. Changing the selects after reset catches a design that does not latch them. In slave mode a receiver in the bench samples on its own rising edges. It stops the frame clock in the middle of a half to check that the line drops after the timeout and comes back only after a fresh valid left half; a design that recovers too early sends data in the frame that should be silent.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

    localparam int SLOT_BITS = 32;
    localparam int TX_BITS   = 20;
    localparam int DIV_W     = 4;

    typedef struct packed {
        logic             master;
        logic             slave;
        logic             bypass;
        logic [DIV_W-1:0] div;
    } role_t;

    // clock-mode code -> role and master-clock divider (ratio / 64)
    function automatic role_t decode_role(input logic [2:0] code);
        role_t r;
        r = '0;
        case (code)
            3'd0: begin r.master = 1'b1; r.div = 4'd4;  end
            3'd1: begin r.master = 1'b1; r.div = 4'd6;  end
            3'd2: begin r.master = 1'b1; r.div = 4'd8;  end
            3'd3: begin r.master = 1'b1; r.div = 4'd12; end
            3'd4: r.slave = 1'b1;
            3'd7: begin r.master = 1'b1; r.bypass = 1'b1; r.div = 4'd4; end
            default: r = '0;
        endcase
        return r;
    endfunction

    // frame-clock level that marks the left half
    function automatic logic left_level(input logic [1:0] f);
        return (f != 2'd3);
    endfunction

endpackage

// File: rtl/aud_ser_bclk_gen.sv
module aud_ser_bclk_gen #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic          bclk,
    output logic          fall
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          bclk;
    } st_t;

    st_t  s_q, s_d;
    logic last, mid;

    always_comb begin
        last = en && (s_q.cnt == div - DW'(1));
        mid  = en && (s_q.cnt == (div >> 1) - DW'(1));
        s_d  = s_q;
        if (!rst_n) begin
            s_d = '0;
        end else if (en) begin
            s_d.cnt = last ? '0 : s_q.cnt + DW'(1);
            if (mid)  s_d.bclk = 1'b1;
            if (last) s_d.bclk = 1'b0;
        end
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign bclk = s_q.bclk;
    assign fall = last;
endmodule

// File: rtl/aud_ser_slave_trk.sv
module aud_ser_slave_trk #(
    parameter int TMO = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bclk_in,
    input  logic lrclk_in,
    output logic fall,
    output logic lr,
    output logic tmo
);
    localparam int TW = $clog2(TMO + 1);

    typedef struct packed {
        logic          b1;
        logic          b2;
        logic          bp;
        logic          l1;
        logic          l2;
        logic          lp;
        logic [TW-1:0] cnt;
        logic          tmo;
    } st_t;

    st_t  s_q, s_d;
    logic lr_edge;

    always_comb begin
        fall    = en & s_q.bp & ~s_q.b2;
        lr_edge = s_q.l2 ^ s_q.lp;
        s_d     = s_q;
        if (!rst_n) begin
            s_d = '0;
        end else begin
            s_d.b1 = bclk_in;
            s_d.b2 = s_q.b1;
            s_d.bp = s_q.b2;
            s_d.l1 = lrclk_in;
            s_d.l2 = s_q.l1;
            s_d.lp = s_q.l2;
            if (!en || lr_edge) begin
                s_d.cnt = '0;
                s_d.tmo = 1'b0;
            end else if (s_q.cnt == TW'(TMO)) begin
                s_d.tmo = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign lr  = s_q.l2;
    assign tmo = s_q.tmo;
endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift
    import aud_ser_pkg::*;
#(
    parameter int SW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fmt,
    input  logic          slave,
    input  logic          fall,
    input  logic          lr_in,
    input  logic          kill,
    input  logic [SW-1:0] left_i,
    input  logic [SW-1:0] right_i,
    input  logic          valid,
    output logic          sdata,
    output logic          lr_o,
    output logic [4:0]    pos_o
);
    typedef struct packed {
        logic [SLOT_BITS-1:0] sr;
        logic [SW-1:0]        rhold;
        logic [4:0]           pos;
        logic                 half;
        logic                 live;
    } st_t;

    st_t                  s_q, s_d;
    logic                 lvl_left, bnd, nxt_half;
    logic [SW-1:0]        smp;
    logic [TX_BITS-1:0]   s20;
    logic [SLOT_BITS-1:0] word;

    always_comb begin
        lvl_left = left_level(fmt);
        if (slave) begin
            nxt_half = (lr_in != lvl_left);
            bnd      = fall && (nxt_half != s_q.half);
        end else begin
            nxt_half = ~s_q.half;
            bnd      = fall && (s_q.pos == 5'd31);
        end
        smp = nxt_half ? s_q.rhold : left_i;
        s20 = smp[SW-1 -: TX_BITS];
        case (fmt)
            2'd0:    word = {16'd0, s20[TX_BITS-1 -: 16]};
            2'd1:    word = {{(SLOT_BITS-TX_BITS){1'b0}}, s20};
            2'd2:    word = {s20, {(SLOT_BITS-TX_BITS){1'b0}}};
            default: word = {1'b0, s20, {(SLOT_BITS-TX_BITS-1){1'b0}}};
        endcase

        s_d = s_q;
        if (!rst_n) begin
            s_d      = '0;
            s_d.pos  = 5'd31;
            s_d.half = 1'b1;
        end else begin
            if (fall) begin
                if (bnd) begin
                    s_d.sr   = word;
                    s_d.pos  = 5'd0;
                    s_d.half = nxt_half;
                    if (!nxt_half) begin
                        s_d.rhold = right_i;
                        if (valid) s_d.live = 1'b1;
                    end
                end else begin
                    s_d.sr = {s_q.sr[SLOT_BITS-2:0], 1'b0};
                    if (s_q.pos != 5'd31) s_d.pos = s_q.pos + 5'd1;
                end
            end
            if (kill) begin
                s_d.live = 1'b0;
                s_d.sr   = '0;
            end
        end
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign sdata = s_q.live & s_q.sr[SLOT_BITS-1];
    assign lr_o  = s_q.half ? ~lvl_left : lvl_left;
    assign pos_o = s_q.pos;
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int SW  = 20,
    parameter int TMO = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    clk_mode_i,
    input  logic [1:0]    fmt_i,
    input  logic [SW-1:0] left_i,
    input  logic [SW-1:0] right_i,
    input  logic          smp_valid_i,
    input  logic          bclk_i,
    input  logic          lrclk_i,
    output logic          bclk_o,
    output logic          lrclk_o,
    output logic          sdata_o,
    output logic          bypass_o
);
    typedef struct packed {
        logic [2:0] mode;
        logic [1:0] fmt;
    } cfg_t;

    cfg_t  cfg_q, cfg_d;
    role_t role;
    logic  mfall, mbclk, sfall, slr, tmo, fall, lr_m, sdata;
    logic  is_master;
    logic [4:0] pos;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.mode = clk_mode_i;
            cfg_d.fmt  = fmt_i;
        end
    end

    always_ff @(posedge clk) cfg_q <= cfg_d;

    assign role      = decode_role(cfg_q.mode);
    assign is_master = role.master;

    aud_ser_bclk_gen #(.DW(DIV_W)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (role.master),
        .div   (role.div),
        .bclk  (mbclk),
        .fall  (mfall)
    );

    aud_ser_slave_trk #(.TMO(TMO)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (role.slave),
        .bclk_in  (bclk_i),
        .lrclk_in (lrclk_i),
        .fall     (sfall),
        .lr       (slr),
        .tmo      (tmo)
    );

    assign fall = role.master ? mfall : sfall;

    aud_ser_shift #(.SW(SW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt     (cfg_q.fmt),
        .slave   (role.slave),
        .fall    (fall),
        .lr_in   (slr),
        .kill    (tmo),
        .left_i  (left_i),
        .right_i (right_i),
        .valid   (smp_valid_i),
        .sdata   (sdata),
        .lr_o    (lr_m),
        .pos_o   (pos)
    );

    assign bclk_o   = role.master & mbclk;
    assign lrclk_o  = role.master & lr_m;
    assign sdata_o  = sdata;
    assign bypass_o = role.bypass;
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic [1:0] fmt,
    input logic       is_master,
    input logic       mfall,
    input logic       fall,
    input logic       tmo,
    input logic [4:0] pos,
    input logic       bclk_o,
    input logic       lrclk_o,
    input logic       sdata_o
);
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($stable(mode) && $stable(fmt))); // R1

    AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mfall |-> bclk_o); // R2

    AST_LR_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !mfall) |=> $stable(lrclk_o)); // R3

    AST_QUIET_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (!bclk_o && !lrclk_o)); // R4

    AST_RSV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 || mode == 3'd6) |-> !sdata_o); // R4

    AST_SD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !tmo) |=> $stable(sdata_o)); // R5

    AST_LJ_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 2'd2 && pos >= 5'd20) |-> !sdata_o); // R8

    AST_TMO_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !sdata_o); // R12
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (cfg_q.mode),
    .fmt       (cfg_q.fmt),
    .is_master (is_master),
    .mfall     (mfall),
    .fall      (fall),
    .tmo       (tmo),
    .pos       (pos),
    .bclk_o    (bclk_o),
    .lrclk_o   (lrclk_o),
    .sdata_o   (sdata_o)
);

// File: tb/sim_aud_ser_tx.sv
module sim_aud_ser_tx;
    localparam int CLK_PERIOD = 10;
    localparam int SW  = 20;
    localparam int TMO = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    clk_mode_i = 3'd0;
    logic [1:0]    fmt_i = 2'd0;
    logic [SW-1:0] left_i = '0;
    logic [SW-1:0] right_i = '0;
    logic          smp_valid_i = 1'b0;
    logic          bclk_i = 1'b0;
    logic          lrclk_i = 1'b0;
    logic          bclk_o, lrclk_o, sdata_o, bypass_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;

    aud_ser_tx #(.SW(SW), .TMO(TMO)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    function automatic int div_of(input logic [2:0] c);
        case (c)
            3'd1: return 6;
            3'd2: return 8;
            3'd3: return 12;
            default: return 4;
        endcase
    endfunction

    // expected bit at slot position p (0 = first bit after the half boundary)
    function automatic logic bitof(input logic [1:0] f, input logic [19:0] s, input int p);
        case (f)
            2'd0: return (p >= 16) ? s[19-(p-16)] : 1'b0;
            2'd1: return (p >= 12) ? s[19-(p-12)] : 1'b0;
            2'd2: return (p < 20) ? s[19-p] : 1'b0;
            default: return (p >= 1 && p <= 20) ? s[20-p] : 1'b0;
        endcase
    endfunction

    function automatic string fmt_tag(input logic [1:0] f);
        case (f)
            2'd0: return "R6";
            2'd1: return "R7";
            2'd2: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic new_samples();
        seed = seed * 32'd1103515245 + 32'd12345;
        left_i = seed[27:8];
        seed = seed * 32'd1103515245 + 32'd12345;
        right_i = seed[27:8];
    endtask

    // ---------------- master-mode reference model ----------------
    logic mdl_on = 1'b0;
    int k, m, b, h, p, nd;
    logic lv, eb, elr, esd;
    logic [19:0] mL, mR;
    logic [2:0] mcm;
    logic [1:0] mcf;

    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0; lv = 1'b0; mcm = clk_mode_i; mcf = fmt_i;
            eb = 1'b0; elr = (mcf == 2'd3); esd = 1'b0;
        end else begin
            k++;
            nd = div_of(mcm);
            eb = ((k % nd) >= nd/2);
            if (k % nd == 0) begin
                m = k / nd;
                b = (m - 1) % 64;
                h = b / 32;
                p = b % 32;
                if (b == 0) begin
                    mL = left_i; mR = right_i;
                    if (smp_valid_i) lv = 1'b1;
                end
                elr = (h == 0) ? (mcf != 2'd3) : (mcf == 2'd3);
                esd = lv & bitof(mcf, (h != 0) ? mR : mL, p);
            end
        end
    end

    always @(negedge clk) begin
        if (mdl_on && rst_n) begin
            chk("R2 bclk", {31'd0, bclk_o}, {31'd0, eb});
            chk("R3 lrclk", {31'd0, lrclk_o}, {31'd0, elr});
            chk(lv ? fmt_tag(mcf) : "R10", {31'd0, sdata_o}, {31'd0, esd});
        end
    end

    task automatic run_master(input logic [2:0] code, input logic [1:0] f, input int vdelay);
        int total;
        total = 3 * 64 * div_of(code) + 10;
        rst_n = 1'b0; clk_mode_i = code; fmt_i = f; smp_valid_i = (vdelay == 0);
        new_samples();
        repeat (3) @(negedge clk);
        chk("R10 reset", {30'd0, bclk_o, sdata_o}, 32'd0);
        mdl_on = 1'b1;
        rst_n = 1'b1;
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            if (i == vdelay) smp_valid_i = 1'b1;
            if (i % 97 == 0) new_samples();
            if (i == 50) begin clk_mode_i = ~code; fmt_i = ~f; end  // R1: ignored
        end
        mdl_on = 1'b0;
        chk("R1 R13 bypass", {31'd0, bypass_o}, {31'd0, (code == 3'd7)});
    endtask

    // ---------------- slave-mode receiver ----------------
    logic       prev_chk = 1'b0;
    logic       prev_exp = 1'b0;
    string      prev_tag = "R11";

    task automatic s_bit(input logic lrv);
        @(negedge clk);
        if (prev_chk) chk(prev_tag, {31'd0, sdata_o}, {31'd0, prev_exp});
        bclk_i = 1'b1;
        repeat (3) @(negedge clk);
        bclk_i = 1'b0;
        lrclk_i = lrv;
        repeat (3) @(negedge clk);
    endtask

    task automatic s_frame(input logic [1:0] f, input logic live, input int nbits);
        logic ll;
        ll = (f != 2'd3);
        for (int bi = 0; bi < nbits; bi++) begin
            s_bit((bi < 32) ? ll : ~ll);
            prev_chk = 1'b1;
            prev_tag = live ? "R11" : "R12";
            prev_exp = live & bitof(f, (bi < 32) ? left_i : right_i, bi % 32);
        end
    endtask

    task automatic slave_start(input logic [1:0] f);
        rst_n = 1'b0; clk_mode_i = 3'd4; fmt_i = f; smp_valid_i = 1'b1;
        bclk_i = 1'b0; lrclk_i = (f == 2'd3);
        prev_chk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 slave clocks", {30'd0, bclk_o, lrclk_o}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // master runs: every divider and every format
        run_master(3'd0, 2'd0, 64*4 + 20);   // R10: valid only from frame 1
        run_master(3'd1, 2'd1, 0);
        run_master(3'd2, 2'd2, 0);
        run_master(3'd3, 2'd3, 0);
        run_master(3'd7, 2'd2, 0);

        // reserved codes: R4
        for (int c = 5; c <= 6; c++) begin
            rst_n = 1'b0; clk_mode_i = 3'(c); fmt_i = 2'd2; smp_valid_i = 1'b1;
            left_i = 20'hFFFFF; right_i = 20'hFFFFF;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (i % 50 == 0)
                    chk("R4 reserved", {29'd0, bclk_o, lrclk_o, sdata_o}, 32'd0);
            end
        end

        // slave, right-justified 20: R11
        slave_start(2'd1);
        new_samples(); s_frame(2'd1, 1'b1, 64);
        new_samples(); s_frame(2'd1, 1'b1, 64);

        // slave, I2S layout, then timeout: R11, R12
        slave_start(2'd3);
        new_samples(); s_frame(2'd3, 1'b1, 64);
        new_samples(); s_frame(2'd3, 1'b1, 64);
        left_i = 20'h9_5A3C; right_i = 20'h1_2345;
        s_frame(2'd3, 1'b1, 2);              // clocks stop after position 1 (MSB = 1)
        @(negedge clk);
        chk("R11 msb before stop", {31'd0, sdata_o}, 32'd1);
        repeat (TMO + 20) @(negedge clk);
        chk("R12 silenced", {31'd0, sdata_o}, 32'd0);
        prev_chk = 1'b0;
        new_samples(); s_frame(2'd3, 1'b0, 64);   // R12: no data until a fresh left half
        new_samples(); s_frame(2'd3, 1'b1, 64);
        s_bit(1'b0);                               // sample last position

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule